// File: doc/BRIEF.md
# Cascadable Binary Rate Multiplier

This block turns a stream of input strobes into a thinner stream of output pulses. Each of its two 4-bit stages holds a small counter and a rate word N. For every sixteen strobes a stage sees, it emits exactly N one-clock pulses, spread over that window. Each set bit of the word adds its own evenly spaced pulse train.

A mode input selects how the two stages are chained.
- **Add mode:** the high stage runs on every strobe. The low stage advances only in the one slot per sixteen where the high stage is at its final count and can never fire. The low stage fills that gap, so the combined rate is N_hi/16 + N_lo/256.
- **Multiply mode:** the low stage is stepped by the high stage's own pulses. The combined rate is (N_hi/16)·(N_lo/16).

The block is used for fractional frequency synthesis and for pulse-rate arithmetic.

Top module: `cascade_rate_mult`

## Requirements
- R1: After reset, with a constant word, the high stage emits exactly word_hi pulses on pulse_hi for every 16 strobes.
- R2: Rate-word bit k (k = 0..3) fires when the stage's counter value c satisfies c mod 2^(4-k) = 2^(3-k) - 1. Bit 3 therefore fires on even counts and bit 0 fires at count 7. No bit fires at count 15, and no two bits fire at the same count.
- R3: A stage counter advances only on the cycles that enable it. A cycle with strobe low produces no pulse on any output and leaves all counts unchanged.
- R4: Every output is registered. A pulse appears in the cycle after the enabling strobe and lasts exactly one clock.
- R5: tc_hi is high in the cycle after a strobe that arrives while the high counter is at 15.
- R6: In add mode (mul_mode = 0), the following hold:
  - the low stage advances only on strobes at high count 15;
  - pulse_out is the OR of pulse_hi and pulse_lo;
  - over 256 strobes from reset, pulse_out counts 16·word_hi + word_lo pulses.
- R7: In multiply mode (mul_mode = 1), the following hold:
  - the low stage advances only on strobes that produce a high-stage pulse;
  - pulse_out equals pulse_lo;
  - over 256 strobes from reset, pulse_out counts word_hi·word_lo pulses.
- R8: A synchronous reset (rst = 1) clears both counters to zero and forces every output low in the following cycle, even if strobe is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe | input | 1 | Input pulse / clock enable |
| word_hi | input | 4 | Rate word of the high (first) stage |
| word_lo | input | 4 | Rate word of the low (second) stage |
| mul_mode | input | 1 | 0 = add cascade, 1 = multiply cascade |
| pulse_out | output | 1 | Combined output pulse |
| pulse_hi | output | 1 | High stage output pulse |
| pulse_lo | output | 1 | Low stage output pulse |
| tc_hi | output | 1 | High stage terminal-count pulse |

## Verification
Every pair of rate words is run in both modes for 256 back-to-back strobes. The final pulse totals tell the additive gap-filling chain apart from the multiplicative one: for example, words 11 and 13 give 189 pulses in add mode and 143 in multiply mode. A cycle-level model also checks the position of each pulse, which catches trains that collide or fire at count 15 even where the totals would still match. Runs with irregular gaps in the strobe stream confirm that idle cycles neither advance the counters nor emit pulses. A reset issued mid-run, with strobe held high, confirms that the outputs are cleared and that counting restarts from zero.

// File: rtl/cascade_rate_mult.sv
module cascade_rate_mult #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         strobe,
  input  logic [W-1:0] word_hi,
  input  logic [W-1:0] word_lo,
  input  logic         mul_mode,
  output logic         pulse_out,
  output logic         pulse_hi,
  output logic         pulse_lo,
  output logic         tc_hi
);
  logic [W-1:0] cnt_a, cnt_b;
  logic         mode_q;

  function automatic logic train_hit(input logic [W-1:0] c, input logic [W-1:0] w);
    logic f;
    f = 1'b0;
    for (int k = 0; k < W; k++) begin
      logic [W-1:0] mask;
      mask = (W'(1) << (W - 1 - k)) - W'(1);
      if (w[k] && !c[W-1-k] && ((c & mask) == mask)) f = 1'b1;
    end
    return f;
  endfunction

  wire hit_a  = train_hit(cnt_a, word_hi);
  wire hit_b  = train_hit(cnt_b, word_lo);
  wire full_a = &cnt_a;
  wire en_b   = strobe & (mul_mode ? hit_a : full_a);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_a    <= '0;
      cnt_b    <= '0;
      pulse_hi <= 1'b0;
      pulse_lo <= 1'b0;
      tc_hi    <= 1'b0;
      mode_q   <= 1'b0;
    end else begin
      if (strobe) cnt_a <= cnt_a + W'(1);
      if (en_b)   cnt_b <= cnt_b + W'(1);
      pulse_hi <= strobe & hit_a;
      pulse_lo <= en_b & hit_b;
      tc_hi    <= strobe & full_a;
      mode_q   <= mul_mode;
    end
  end

  assign pulse_out = mode_q ? pulse_lo : (pulse_hi | pulse_lo);

  // R3
  no_idle_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (pulse_hi || tc_hi) |-> $past(strobe));

  // R2
  no_fire_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    tc_hi |-> !pulse_hi);

  // R6
  add_fill_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode_q && pulse_lo) |-> (tc_hi && !pulse_hi));

  // R7
  mul_chain_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q && pulse_lo) |-> pulse_hi);

  // R8
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!pulse_hi && !pulse_lo && !tc_hi && !pulse_out));
endmodule

// File: tb/cascade_rate_mult_test.sv
module cascade_rate_mult_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strobe = 1'b0;
  logic [3:0] word_hi = '0, word_lo = '0;
  logic mul_mode = 1'b0;
  logic pulse_out, pulse_hi, pulse_lo, tc_hi;

  int checks = 0, failures = 0, total = 0;
  bit armed = 0, done = 0;
  int ma = 0, mb = 0;
  bit e_hi = 0, e_lo = 0, e_tc = 0, e_mode = 0;

  always #4 clk = ~clk;

  cascade_rate_mult uut (
    .clk(clk), .rst(rst), .strobe(strobe), .word_hi(word_hi), .word_lo(word_lo),
    .mul_mode(mul_mode), .pulse_out(pulse_out), .pulse_hi(pulse_hi),
    .pulse_lo(pulse_lo), .tc_hi(tc_hi));

  function automatic bit sched(int c, logic [3:0] w);
    for (int k = 0; k < 4; k++)
      if (w[k] && (c % (1 << (4 - k))) == (1 << (3 - k)) - 1) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      ma = 0; mb = 0; e_hi = 0; e_lo = 0; e_tc = 0; e_mode = 0;
      armed = 1;
    end else begin
      bit ha, fin, en;
      ha  = strobe && sched(ma, word_hi);
      fin = strobe && ma == 15;
      en  = mul_mode ? ha : fin;
      e_lo = en && sched(mb, word_lo);
      e_hi = ha;
      e_tc = fin;
      e_mode = mul_mode;
      if (strobe) ma = (ma + 1) % 16;
      if (en) mb = (mb + 1) % 16;
    end
  end

  task automatic check(bit got, bit exp, string tag);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s t=%0t got=%0b exp=%0b hi=%0d lo=%0d mode=%0b",
               tag, $time, got, exp, word_hi, word_lo, mul_mode);
    end
  endtask

  always @(negedge clk) if (armed && !done) begin
    bit eo;
    eo = e_mode ? e_lo : (e_hi | e_lo);
    check(pulse_hi, e_hi, "R2 pulse_hi");
    check(pulse_lo, e_lo, e_mode ? "R7 pulse_lo" : "R6 pulse_lo");
    check(tc_hi, e_tc, "R5 tc_hi");
    check(pulse_out, eo, "R4 pulse_out");
    if (pulse_out === 1'b1) total++;
  end

  task automatic run(int h, int l, bit m, int gap);
    int hcount;
    word_hi = 4'(h); word_lo = 4'(l); mul_mode = m;
    rst = 1; strobe = 0;
    @(negedge clk);
    rst = 0; total = 0; hcount = 0;
    for (int i = 0; i < 256; i++) begin
      strobe = 1;
      @(negedge clk);
      if (pulse_hi === 1'b1) hcount++;
      if (gap > 0 && (i % 3) == 1) begin
        strobe = 0;
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          checks++;
          if (pulse_out !== 1'b0 || tc_hi !== 1'b0 || pulse_hi !== 1'b0) begin
            failures++;
            $display("FAIL R3 idle-cycle pulse got=%0b exp=0", pulse_out);
          end
        end
      end
    end
    strobe = 0;
    @(negedge clk);
    if (pulse_hi === 1'b1) hcount++;
    checks++;
    if (hcount != 16 * h) begin
      failures++;
      $display("FAIL R1 hi count got=%0d exp=%0d", hcount, 16 * h);
    end
    checks++;
    if (total != (m ? h * l : 16 * h + l)) begin
      failures++;
      $display("FAIL %s total got=%0d exp=%0d", m ? "R7" : "R6", total,
               m ? h * l : 16 * h + l);
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    checks++;
    if (pulse_out !== 0 || pulse_hi !== 0 || pulse_lo !== 0 || tc_hi !== 0) begin
      failures++;
      $display("FAIL R8 reset state got=%0b exp=0", pulse_out);
    end
    run(11, 13, 0, 0);
    run(11, 13, 1, 0);
    run(15, 15, 0, 2);
    run(9, 6, 1, 1);
    for (int m = 0; m < 2; m++)
      for (int h = 0; h < 16; h++)
        for (int l = 0; l < 16; l++)
          run(h, l, m[0], 0);
    // R8: reset mid-run with strobe held high
    word_hi = 4'd8; word_lo = 4'd0; mul_mode = 0; strobe = 1;
    repeat (5) @(negedge clk);
    rst = 1;
    @(negedge clk);
    checks++;
    if (pulse_out !== 0 || pulse_hi !== 0 || tc_hi !== 0) begin
      failures++;
      $display("FAIL R8 outputs during reset got=%0b exp=0", pulse_hi);
    end
    rst = 0;
    @(negedge clk);
    checks++;
    if (pulse_hi !== 1'b1) begin
      failures++;
      $display("FAIL R8 count restart got=%0b exp=1", pulse_hi);
    end
    strobe = 0;
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 190000);
    failures++;
    done = 1;
    $display("FAIL watchdog expired got=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule